// File: doc/BRIEF.md
# Sliding Window Sum and Sum-of-Squares Unit

This unit takes a raster-order stream of unsigned pixels and, for every position of a rectangular window sliding over the image, produces the sum of the pixels under the window and the sum of their squares. These two numbers are the per-position statistics a zero-mean normalized correlation stage needs alongside its cross-product term. Image width, window width and window height are configuration inputs held steady for a frame.

Each image column owns one entry in a column store: a running sum and a running sum of squares over the most recent window-height pixels of that column. An arriving pixel updates its column entry by adding itself and removing the pixel that drops out of the column's height span; that departing pixel comes from an external row buffer on its own input. Along a row, the window value is then carried forward by adding the freshly updated column entering on the right and removing the column leaving on the left, so no window is ever re-summed from scratch. A duplicate of the column store serves the reads of the departing column.

Top module: `wss_top`

## Requirements
- R1: While rst_ni is low, and until the first window result, win_valid_o is 0.
- R2: For a pixel at row r, column c with r >= h-1 and c >= w-1 (h = cfg_win_h_i, w = cfg_win_w_i), win_sum_o equals the sum of all pixels in rows r-h+1..r and columns c-w+1..c.
- R3: With the same qualification, win_sq_o equals the sum of the squares of those pixels.
- R4: No result is flagged for pixels in the first h-1 rows of a frame or in the first w-1 columns of any row.
- R5: Exactly one result is produced per qualifying pixel, (H-h+1)*(W-w+1) per frame of H rows and width W, in raster order.
- R6: The result for a pixel sampled on rising edge k is presented on win_valid_o, win_sum_o and win_sq_o after rising edge k+2.
- R7: A pixel presented with sof_i high is row 0, column 0 of a new frame; column contents from earlier frames do not affect the new frame's results.
- R8: During the first h rows of a frame, pix_old_i has no effect on any result.
- R9: Idle cycles (pix_valid_i low) between pixels do not change any result; each result still follows its own pixel by the R6 latency.
- R10: A 1x1 window on an image one pixel wide gives each pixel and its square, including back-to-back updates of the same column.
- R11: An 80x80 window of pixels all 255 gives sum 1632000 and sum of squares 416160000 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_img_w_i | input | 10 | Image width in pixels, 1..512 |
| cfg_win_w_i | input | 7 | Window width, 1..80 |
| cfg_win_h_i | input | 7 | Window height, 1..80 |
| sof_i | input | 1 | Marks the first pixel of a frame (qualified by pix_valid_i) |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_i | input | 8 | Incoming pixel |
| pix_old_i | input | 8 | Pixel leaving this column, from h rows above |
| win_valid_o | output | 1 | Window result strobe |
| win_sum_o | output | 22 | Window pixel sum |
| win_sq_o | output | 30 | Window sum of squared pixels |

## Verification
A pixel sampled on edge k has its column entry read at edge k, rewritten at edge k+1 together with the read of the departing column, and folded into the window at edge k+2, so its result is visible after edge k+2. The bench records the edge count when it drives each qualifying pixel and stores the due edge with the brute-force expected pair; the monitor samples on the falling edge and compares both the values and the edge number on which each result appears. Frames with idle gaps, a 1-pixel-wide image and a 512-wide image with the largest window exercise that latency under back-to-back and sparse traffic.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef struct packed {
    logic first_row;  // row 0: stored column entry treated as empty
    logic leave_on;   // row >= h: subtract departing pixel
    logic col0;       // first column of a row
    logic col_ge_w;   // a column leaves the window
    logic out_ok;     // position carries a full window
  } pos_flags_t;
endpackage

// File: rtl/wss_col_ram.sv
module wss_col_ram #(
  parameter int DW    = 38,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          re_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
    // write-first: same-address read sees the value being written
    if (re_i) rd_o <= (we_i && wa_i == ra_i) ? wd_i : mem[ra_i];
  end
endmodule

// File: rtl/wss_pos_ctr.sv
module wss_pos_ctr
  import wss_pkg::*;
#(
  parameter int MAX_IMG = 512,
  parameter int MAX_WIN = 80,
  localparam int AW   = $clog2(MAX_IMG),
  localparam int IW_W = $clog2(MAX_IMG + 1),
  localparam int WB   = $clog2(MAX_WIN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_valid_i,
  input  logic            sof_i,
  input  logic [IW_W-1:0] cfg_img_w_i,
  input  logic [WB-1:0]   cfg_win_w_i,
  input  logic [WB-1:0]   cfg_win_h_i,
  output logic [AW-1:0]   col_o,
  output pos_flags_t      flags_o
);
  logic [AW-1:0]   col_q;
  logic [IW_W-1:0] row_q;
  logic [IW_W-1:0] cur_row, col_ext, ww, wh;
  logic            last_col;

  assign col_o    = sof_i ? '0 : col_q;
  assign cur_row  = sof_i ? '0 : row_q;
  assign col_ext  = IW_W'(col_o);
  assign ww       = IW_W'(cfg_win_w_i);
  assign wh       = IW_W'(cfg_win_h_i);
  assign last_col = (col_ext == cfg_img_w_i - 1'b1);

  always_comb begin
    flags_o.first_row = (cur_row == '0);
    flags_o.leave_on  = (cur_row >= wh);
    flags_o.col0      = (col_o == '0);
    flags_o.col_ge_w  = (col_ext >= ww);
    flags_o.out_ok    = ({1'b0, col_ext} + 1'b1 >= {1'b0, ww}) &&
                        ({1'b0, cur_row} + 1'b1 >= {1'b0, wh});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_valid_i) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= (cur_row == {IW_W{1'b1}}) ? cur_row : cur_row + 1'b1;
      end else begin
        col_q <= col_o + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/wss_col_upd.sv
module wss_col_upd #(
  parameter int PIX_W = 8,
  parameter int COL_W = 15,
  parameter int SQC_W = 23
) (
  input  logic [COL_W-1:0] base_sum_i,
  input  logic [SQC_W-1:0] base_sq_i,
  input  logic             first_row_i,
  input  logic             leave_on_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] old_i,
  output logic [COL_W-1:0] sum_o,
  output logic [SQC_W-1:0] sq_o
);
  logic [COL_W-1:0] b_sum, o_sum;
  logic [SQC_W-1:0] b_sq, o_sq, p_sq;

  always_comb begin
    b_sum = first_row_i ? '0 : base_sum_i;
    b_sq  = first_row_i ? '0 : base_sq_i;
    o_sum = leave_on_i ? COL_W'(old_i) : '0;
    o_sq  = leave_on_i ? SQC_W'(old_i) * SQC_W'(old_i) : '0;
    p_sq  = SQC_W'(pix_i) * SQC_W'(pix_i);
    sum_o = b_sum + COL_W'(pix_i) - o_sum;
    sq_o  = b_sq + p_sq - o_sq;
  end
endmodule

// File: rtl/wss_win_acc.sv
module wss_win_acc #(
  parameter int COL_W = 15,
  parameter int SQC_W = 23,
  parameter int WS_W  = 22,
  parameter int WQ_W  = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             col0_i,
  input  logic             col_ge_w_i,
  input  logic             out_ok_i,
  input  logic [COL_W-1:0] new_sum_i,
  input  logic [SQC_W-1:0] new_sq_i,
  input  logic [COL_W-1:0] lv_sum_i,
  input  logic [SQC_W-1:0] lv_sq_i,
  output logic             valid_o,
  output logic [WS_W-1:0]  sum_o,
  output logic [WQ_W-1:0]  sq_o
);
  logic [WS_W-1:0] sum_d, lv_s;
  logic [WQ_W-1:0] sq_d, lv_q;

  always_comb begin
    lv_s  = col_ge_w_i ? WS_W'(lv_sum_i) : '0;
    lv_q  = col_ge_w_i ? WQ_W'(lv_sq_i)  : '0;
    sum_d = (col0_i ? '0 : sum_o) + WS_W'(new_sum_i) - lv_s;
    sq_d  = (col0_i ? '0 : sq_o)  + WQ_W'(new_sq_i)  - lv_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      sq_o    <= '0;
    end else begin
      valid_o <= in_valid_i && out_ok_i;
      if (in_valid_i) begin
        sum_o <= sum_d;
        sq_o  <= sq_d;
      end
    end
  end
endmodule

// File: rtl/wss_top.sv
module wss_top
  import wss_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int MAX_WIN = 80,
  parameter int MAX_IMG = 512,
  localparam int AW    = $clog2(MAX_IMG),
  localparam int IW_W  = $clog2(MAX_IMG + 1),
  localparam int WB    = $clog2(MAX_WIN + 1),
  localparam int COL_W = PIX_W + WB,
  localparam int SQC_W = 2 * PIX_W + WB,
  localparam int WS_W  = COL_W + WB,
  localparam int WQ_W  = SQC_W + WB,
  localparam int DW    = COL_W + SQC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW_W-1:0]  cfg_img_w_i,
  input  logic [WB-1:0]    cfg_win_w_i,
  input  logic [WB-1:0]    cfg_win_h_i,
  input  logic             sof_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] pix_old_i,
  output logic             win_valid_o,
  output logic [WS_W-1:0]  win_sum_o,
  output logic [WQ_W-1:0]  win_sq_o
);
  logic [AW-1:0]    cur_col;
  pos_flags_t       cur_fl;

  // stage 1: column read returned, column update
  logic             s1_vld;
  logic [AW-1:0]    s1_col;
  logic [PIX_W-1:0] s1_pix, s1_old;
  pos_flags_t       s1_fl;
  logic [DW-1:0]    main_rd, shad_rd;
  logic [COL_W-1:0] upd_sum;
  logic [SQC_W-1:0] upd_sq;

  // stage 2: window fold
  logic             s2_vld, s2_col0, s2_ge_w, s2_ok;
  logic [COL_W-1:0] s2_sum;
  logic [SQC_W-1:0] s2_sq;

  wss_pos_ctr #(.MAX_IMG(MAX_IMG), .MAX_WIN(MAX_WIN)) u_pos (
    .clk_i, .rst_ni, .pix_valid_i, .sof_i,
    .cfg_img_w_i, .cfg_win_w_i, .cfg_win_h_i,
    .col_o(cur_col), .flags_o(cur_fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_col <= '0;
      s1_pix <= '0;
      s1_old <= '0;
      s1_fl  <= '0;
    end else begin
      s1_vld <= pix_valid_i;
      if (pix_valid_i) begin
        s1_col <= cur_col;
        s1_pix <= pix_i;
        s1_old <= pix_old_i;
        s1_fl  <= cur_fl;
      end
    end
  end

  wss_col_ram #(.DW(DW), .DEPTH(MAX_IMG)) u_main (
    .clk_i,
    .we_i(s1_vld), .wa_i(s1_col), .wd_i({upd_sq, upd_sum}),
    .re_i(pix_valid_i), .ra_i(cur_col), .rd_o(main_rd)
  );

  wss_col_upd #(.PIX_W(PIX_W), .COL_W(COL_W), .SQC_W(SQC_W)) u_upd (
    .base_sum_i(main_rd[COL_W-1:0]), .base_sq_i(main_rd[DW-1:COL_W]),
    .first_row_i(s1_fl.first_row), .leave_on_i(s1_fl.leave_on),
    .pix_i(s1_pix), .old_i(s1_old),
    .sum_o(upd_sum), .sq_o(upd_sq)
  );

  // duplicate store gives a read port for the departing column
  wss_col_ram #(.DW(DW), .DEPTH(MAX_IMG)) u_shadow (
    .clk_i,
    .we_i(s1_vld), .wa_i(s1_col), .wd_i({upd_sq, upd_sum}),
    .re_i(s1_vld && s1_fl.col_ge_w), .ra_i(s1_col - AW'(cfg_win_w_i)),
    .rd_o(shad_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_col0 <= 1'b0;
      s2_ge_w <= 1'b0;
      s2_ok   <= 1'b0;
      s2_sum  <= '0;
      s2_sq   <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_col0 <= s1_fl.col0;
        s2_ge_w <= s1_fl.col_ge_w;
        s2_ok   <= s1_fl.out_ok;
        s2_sum  <= upd_sum;
        s2_sq   <= upd_sq;
      end
    end
  end

  wss_win_acc #(.COL_W(COL_W), .SQC_W(SQC_W), .WS_W(WS_W), .WQ_W(WQ_W)) u_acc (
    .clk_i, .rst_ni,
    .in_valid_i(s2_vld), .col0_i(s2_col0), .col_ge_w_i(s2_ge_w), .out_ok_i(s2_ok),
    .new_sum_i(s2_sum), .new_sq_i(s2_sq),
    .lv_sum_i(shad_rd[COL_W-1:0]), .lv_sq_i(shad_rd[DW-1:COL_W]),
    .valid_o(win_valid_o), .sum_o(win_sum_o), .sq_o(win_sq_o)
  );
endmodule

// File: rtl/wss_checker.sv
module wss_checker #(
  parameter int PIX_W   = 8,
  parameter int MAX_WIN = 80,
  localparam int WB    = $clog2(MAX_WIN + 1),
  localparam int WS_W  = PIX_W + 2 * WB,
  localparam int WQ_W  = 2 * PIX_W + 2 * WB
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic [PIX_W-1:0] pix_i,
  input logic [WB-1:0]    cfg_win_w_i,
  input logic [WB-1:0]    cfg_win_h_i,
  input logic             win_valid_o,
  input logic [WS_W-1:0]  win_sum_o,
  input logic [WQ_W-1:0]  win_sq_o
);
  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_quiet_in_reset: assert (!win_valid_o);
  end

  a_r6_result_follows_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> $past(pix_valid_i, 3));

  a_r3_sq_not_below_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> WQ_W'(win_sum_o) <= win_sq_o);

  a_r11_sum_within_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> 32'(win_sum_o) <= 32'(cfg_win_w_i) * 32'(cfg_win_h_i) * PIX_MAX);

  a_r10_unit_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && cfg_win_w_i == 1 && cfg_win_h_i == 1) |->
      (win_sum_o == WS_W'($past(pix_i, 3)) &&
       win_sq_o == WQ_W'($past(pix_i, 3)) * WQ_W'($past(pix_i, 3))));
endmodule

bind wss_top wss_checker #(.PIX_W(PIX_W), .MAX_WIN(MAX_WIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
  .cfg_win_w_i(cfg_win_w_i), .cfg_win_h_i(cfg_win_h_i),
  .win_valid_o(win_valid_o), .win_sum_o(win_sum_o), .win_sq_o(win_sq_o)
);

// File: tb/tb_wss_top.sv
module tb_wss_top;
  localparam int IW_W = 10;
  localparam int WB   = 7;

  logic            clk_i = 0, rst_ni = 0;
  logic [IW_W-1:0] cfg_img_w_i = 16;
  logic [WB-1:0]   cfg_win_w_i = 1, cfg_win_h_i = 1;
  logic            sof_i = 0, pix_valid_i = 0;
  logic [7:0]      pix_i = 0, pix_old_i = 0;
  logic            win_valid_o;
  logic [21:0]     win_sum_o;
  logic [29:0]     win_sq_o;

  wss_top dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0, got = 0;
  longint q_sum[$], q_sq[$], q_due[$];
  int img[];

  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: R2, R3, R6 per result, R4 on any unexpected result
  always @(negedge clk_i) begin
    if (rst_ni && win_valid_o) begin
      if (q_sum.size() == 0) chk(0, "R4 unexpected result", win_sum_o, -1);
      else begin
        got++;
        chk(win_sum_o == q_sum[0], "R2 window sum", win_sum_o, q_sum[0]);
        chk(win_sq_o == q_sq[0], "R3 window sum of squares", win_sq_o, q_sq[0]);
        chk(cyc == q_due[0], "R6 result edge", cyc, q_due[0]);
        void'(q_sum.pop_front()); void'(q_sq.pop_front()); void'(q_due.pop_front());
      end
    end
  end

  task automatic run_frame(input int W, input int H, input int w, input int h,
                           input bit gaps, input int fill, input string tag);
    int exp_n;
    img = new[W * H];
    foreach (img[i]) img[i] = (fill < 0) ? int'($urandom_range(0, 255)) : fill;
    @(negedge clk_i);
    cfg_img_w_i = IW_W'(W); cfg_win_w_i = WB'(w); cfg_win_h_i = WB'(h);
    got = 0;
    exp_n = (H - h + 1) * (W - w + 1);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        if (gaps) begin
          int g = $urandom_range(0, 2);
          pix_valid_i = 0; sof_i = 0;
          repeat (g) @(negedge clk_i);
        end
        pix_valid_i = 1;
        sof_i       = (r == 0 && c == 0);
        pix_i       = 8'(img[r * W + c]);
        // R8: garbage on the departing-pixel input during the first h rows
        pix_old_i   = (r >= h) ? 8'(img[(r - h) * W + c]) : 8'($urandom);
        if (r >= h - 1 && c >= w - 1) begin
          longint s = 0, q = 0;
          for (int y = r - h + 1; y <= r; y++)
            for (int x = c - w + 1; x <= c; x++) begin
              s += img[y * W + x];
              q += img[y * W + x] * img[y * W + x];
            end
          q_sum.push_back(s); q_sq.push_back(q); q_due.push_back(cyc + 3);
        end
        @(negedge clk_i);
      end
    end
    pix_valid_i = 0; sof_i = 0;
    repeat (6) @(negedge clk_i);
    chk(got == exp_n, {"R5 result count ", tag}, got, exp_n);
    chk(q_sum.size() == 0, {"R5 missing results ", tag}, q_sum.size(), 0);
    q_sum.delete(); q_sq.delete(); q_due.delete();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(win_valid_o == 0, "R1 valid low in reset", win_valid_o, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    chk(win_valid_o == 0, "R1 valid low after reset", win_valid_o, 0);
  endtask

  task automatic t_basic();     run_frame(16, 12, 3, 4, 0, -1, "R2 basic"); endtask
  task automatic t_new_frame(); run_frame(16, 12, 5, 2, 0, -1, "R7 refill"); endtask
  task automatic t_gaps();      run_frame(20, 10, 4, 3, 1, -1, "R9 gaps"); endtask
  task automatic t_tall();      run_frame(9, 20, 2, 9, 0, -1, "R4 tall"); endtask
  task automatic t_unit();
    run_frame(1, 8, 1, 1, 0, -1, "R10 single column");
    run_frame(7, 3, 1, 1, 1, -1, "R10 unit window");
  endtask
  task automatic t_full_width(); run_frame(512, 82, 80, 80, 0, -1, "R2 full width"); endtask
  task automatic t_saturated();
    run_frame(80, 80, 80, 80, 0, 255, "R11 all 255");
    chk(1632000 == 80 * 80 * 255, "R11 reference sum", 1632000, 80 * 80 * 255);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    chk(0, "watchdog expired", cyc, 190000);
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_new_frame();
    t_gaps();
    t_tall();
    t_unit();
    t_saturated();
    t_full_width();
    summary();
  end
endmodule